// File: doc/BRIEF.md
# Multiplexed Bus Read Responder

This block sits on the target side of a 32-bit multiplexed address/data bus and answers read requests issued by a CPU. A request is a command cycle: the CPU pulls its valid strobe low, puts the byte address on the shared bus and a 5-bit command on the command bus. The responder decodes the request, waits a programmable number of cycles, then returns one, four or eight 32-bit words on the shared bus. Each word is marked by an active-low external-valid strobe. All bus signals are sampled and driven on the rising edge of one master clock.

Read data comes from a simple synchronous memory port: a read enable and a word address go out, and the word comes back one cycle later. The responder issues each memory read one cycle ahead of the beat that carries it, so the beats of a line fill follow each other with no gap. Bus direction is modelled with separate drive and output-enable signals for the address/data bus and for the command bus.

The state machine has four named states. In `ST_IDLE` it accepts requests. In `ST_WAIT` it counts down the programmed delay and keeps the bus released. In `ST_BEAT` it drives one data word per cycle. `ST_TURN` is a one-cycle turnaround with the bus released. The named transitions are:
- capture (`ST_IDLE` to `ST_WAIT`) when a read command is seen;
- start (`ST_WAIT` to `ST_BEAT`) when the wait count reaches zero;
- advance (`ST_BEAT` to `ST_BEAT`) while beats remain;
- finish (`ST_BEAT` to `ST_TURN`) after the last beat;
- release (`ST_TURN` to `ST_IDLE`).

Top module: `mbus_read_responder`

## Requirements
- R1: After reset, `ad_oe`, `cmd_oe`, `mem_rd_en` and `err_o` are 0, `ext_valid_n` is 1, and no beat appears until a request is accepted.
- R2: A request is accepted only in `ST_IDLE`, and only in a cycle where all three hold: `cmd_valid_n` is 0, `cmd_in[4]` is 0 (command cycle, not data cycle) and `cmd_in[3]` is 0 (read, not write). Write commands, data cycles and cycles with `cmd_valid_n` high produce no beat and no memory read.
- R3: `cmd_in[1:0]` selects the read size: 00 is a single word (1 beat), 01 is a 128-bit data-line fill (4 beats) and 10 is a 256-bit instruction-line fill (8 beats). `cmd_in[2]` is ignored.
- R4: With `wait_cycles` = W captured at the accepting edge, the first beat is driven in the cycle that follows the (W+1)th rising edge after the accepting edge. Until then `ext_valid_n` stays 1 and `ad_oe` stays 0.
- R5: The beats of a request fill consecutive cycles. During each beat, `ext_valid_n` is 0, `ad_oe` and `cmd_oe` are 1 and `cmd_out[4]` is 1 (data cycle). `cmd_out[0]` is 1 only on the last beat.
- R6: A single-word read returns the memory word at word address `ad_in[31:2]`.
- R7: A data-line read with address bit 4 low returns the line at `ad_in[31:4]` in word offsets 0, 1, 2, 3.
- R8: A data-line read with address bit 4 high returns the 64-bit half selected by address bit 3 first (lower word, then upper word), and then the other half. With bit 3 high the offset order is 2, 3, 0, 1.
- R9: An instruction-line read returns the eight words at `ad_in[31:5]` in offset order 0 to 7. Address bits 4:0 are ignored.
- R10: In the cycle after the last beat, `ext_valid_n` is 1 and both `ad_oe` and `cmd_oe` are 0. A request presented only in that turnaround cycle is ignored.
- R11: Size code 11 returns one beat of zero data flagged as the last beat and performs no memory read. It sets `err_o`, which stays 1 until reset.
- R12: `mem_rd_en` is asserted once per memory-backed beat, in the cycle before that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid_n | input | 1 | CPU valid strobe, active low |
| cmd_in | input | 5 | Command bus as driven by the CPU |
| ad_in | input | 32 | Address/data bus as driven by the CPU |
| wait_cycles | input | 4 | Wait before the first beat, captured with the request |
| ad_out | output | 32 | Read data driven onto the shared bus |
| ad_oe | output | 1 | Drive enable for the shared bus |
| cmd_out | output | 5 | Command bus value driven with each beat |
| cmd_oe | output | 1 | Drive enable for the command bus |
| ext_valid_n | output | 1 | External-valid strobe, active low, one per beat |
| mem_rd_en | output | 1 | Memory read enable |
| mem_addr | output | 30 | Memory word address |
| mem_rdata | input | 32 | Memory read data, valid one cycle after `mem_rd_en` |
| err_o | output | 1 | Sticky flag for an unsupported size code |

## Verification
On every cycle, assertions check several properties:
- a beat always drives both buses and marks a data cycle;
- the bus is released the cycle after a last beat;
- a rejected command leaves the machine idle;
- the beat index advances by one per cycle;
- each memory read is followed by a beat;
- the wait counter counts down by one;
- the error flag never clears.

Other behaviour only the bench scenarios can show:
- word order within the data and instruction lines;
- the exact latency for each wait setting;
- the zero beat for an unsupported size;
- that a request in the turnaround cycle is dropped.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

    localparam int CMD_W         = 5;
    localparam int CMD_DATA_BIT  = 4;
    localparam int CMD_WRITE_BIT = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_BEAT,
        ST_TURN
    } mrr_state_e;

    typedef enum logic [1:0] {
        KIND_WORD  = 2'b00,
        KIND_DLINE = 2'b01,
        KIND_ILINE = 2'b10,
        KIND_BAD   = 2'b11
    } mrr_kind_e;

endpackage

// File: rtl/mrr_cmd_decode.sv
module mrr_cmd_decode
    import mrr_pkg::*;
#(
    parameter int BEAT_W      = 3,
    parameter int DLINE_BEATS = 4,
    parameter int ILINE_BEATS = 8
) (
    input  logic              cmd_valid_n,
    input  logic [CMD_W-1:0]  cmd,
    output logic              req,
    output mrr_kind_e         kind,
    output logic [BEAT_W-1:0] last_idx
);

    logic unused_cmd_bit;
    assign unused_cmd_bit = cmd[2];

    always_comb begin
        req  = !cmd_valid_n && !cmd[CMD_DATA_BIT] && !cmd[CMD_WRITE_BIT];
        kind = mrr_kind_e'(cmd[1:0]);
        unique case (kind)
            KIND_DLINE: last_idx = BEAT_W'(DLINE_BEATS - 1);
            KIND_ILINE: last_idx = BEAT_W'(ILINE_BEATS - 1);
            default:    last_idx = '0;
        endcase
    end

endmodule

// File: rtl/mrr_beat_order.sv
module mrr_beat_order
    import mrr_pkg::*;
#(
    parameter int WA_W        = 30,
    parameter int BEAT_W      = 3,
    parameter int DLINE_BEATS = 4,
    parameter int ILINE_BEATS = 8
) (
    input  mrr_kind_e         kind,
    input  logic [WA_W-1:0]   base_wa,
    input  logic [BEAT_W-1:0] idx,
    output logic [WA_W-1:0]   word_addr
);

    localparam int D_W = $clog2(DLINE_BEATS);

    logic [WA_W-1:0] off;
    logic [WA_W-1:0] mask;

    always_comb begin
        unique case (kind)
            KIND_DLINE: begin
                mask = WA_W'(DLINE_BEATS - 1);
                off  = WA_W'(idx) & mask;
                // critical half first when the ordering bit is set
                if (base_wa[D_W])
                    off[D_W-1] = idx[D_W-1] ^ base_wa[D_W-1];
            end
            KIND_ILINE: begin
                mask = WA_W'(ILINE_BEATS - 1);
                off  = WA_W'(idx) & mask;
            end
            default: begin
                mask = '0;
                off  = '0;
            end
        endcase
        word_addr = (base_wa & ~mask) | off;
    end

endmodule

// File: rtl/mrr_wait_timer.sv
module mrr_wait_timer #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              dec,
    output logic              expired
);

    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    assert_wait_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/mbus_read_responder.sv
module mbus_read_responder
    import mrr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int WAIT_W     = 4,
    parameter int DLINE_BITS = 128,
    parameter int ILINE_BITS = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid_n,
    input  logic [CMD_W-1:0]      cmd_in,
    input  logic [ADDR_W-1:0]     ad_in,
    input  logic [WAIT_W-1:0]     wait_cycles,
    output logic [DATA_W-1:0]     ad_out,
    output logic                  ad_oe,
    output logic [CMD_W-1:0]      cmd_out,
    output logic                  cmd_oe,
    output logic                  ext_valid_n,
    output logic                  mem_rd_en,
    output logic [ADDR_W-3:0]     mem_addr,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  err_o
);

    localparam int BYTE_OFF_W  = $clog2(DATA_W / 8);
    localparam int WA_W        = ADDR_W - BYTE_OFF_W;
    localparam int DLINE_BEATS = DLINE_BITS / DATA_W;
    localparam int ILINE_BEATS = ILINE_BITS / DATA_W;
    localparam int BEAT_W      = $clog2(ILINE_BEATS);

    mrr_state_e        state_q, state_d;
    mrr_kind_e         kind_q, dec_kind;
    logic [WA_W-1:0]   wa_q;
    logic [BEAT_W-1:0] beat_q, last_q, dec_last;
    logic              dec_req, accept, wait_done, last_beat, err_q;
    logic [BEAT_W-1:0] issue_idx;
    logic [WA_W-1:0]   issue_wa;

    mrr_cmd_decode #(
        .BEAT_W(BEAT_W), .DLINE_BEATS(DLINE_BEATS), .ILINE_BEATS(ILINE_BEATS)
    ) i_decode (
        .cmd_valid_n(cmd_valid_n),
        .cmd        (cmd_in),
        .req        (dec_req),
        .kind       (dec_kind),
        .last_idx   (dec_last)
    );

    assign accept = (state_q == ST_IDLE) && dec_req;

    mrr_wait_timer #(.WAIT_W(WAIT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .load_val(wait_cycles),
        .dec     (state_q == ST_WAIT),
        .expired (wait_done)
    );

    assign last_beat = (beat_q == last_q);
    assign issue_idx = (state_q == ST_WAIT) ? '0 : beat_q + 1'b1;

    mrr_beat_order #(
        .WA_W(WA_W), .BEAT_W(BEAT_W),
        .DLINE_BEATS(DLINE_BEATS), .ILINE_BEATS(ILINE_BEATS)
    ) i_order (
        .kind     (kind_q),
        .base_wa  (wa_q),
        .idx      (issue_idx),
        .word_addr(issue_wa)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)    state_d = ST_WAIT;
            ST_WAIT: if (wait_done) state_d = ST_BEAT;
            ST_BEAT: if (last_beat) state_d = ST_TURN;
            ST_TURN:                state_d = ST_IDLE;
        endcase
    end

    // state register and request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= KIND_WORD;
            wa_q    <= '0;
            beat_q  <= '0;
            last_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                kind_q <= dec_kind;
                wa_q   <= ad_in[ADDR_W-1:BYTE_OFF_W];
                last_q <= dec_last;
                beat_q <= '0;
                if (dec_kind == KIND_BAD)
                    err_q <= 1'b1;
            end else if (state_q == ST_BEAT && !last_beat) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ad_oe       = 1'b0;
        cmd_oe      = 1'b0;
        ext_valid_n = 1'b1;
        ad_out      = '0;
        cmd_out     = '0;
        mem_rd_en   = 1'b0;
        mem_addr    = issue_wa;
        unique case (state_q)
            ST_WAIT: begin
                mem_rd_en = wait_done && (kind_q != KIND_BAD);
            end
            ST_BEAT: begin
                ad_oe       = 1'b1;
                cmd_oe      = 1'b1;
                ext_valid_n = 1'b0;
                ad_out      = (kind_q == KIND_BAD) ? '0 : mem_rdata;
                cmd_out[CMD_DATA_BIT] = 1'b1;
                cmd_out[0]  = last_beat;
                mem_rd_en   = !last_beat && (kind_q != KIND_BAD);
            end
            default: ;
        endcase
    end

    assign err_o = err_q;

    assert_beat_drives_buses_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_valid_n |-> (ad_oe && cmd_oe && cmd_out[CMD_DATA_BIT]));

    assert_beat_index_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BEAT && !last_beat) |=> (state_q == ST_BEAT && beat_q == $past(beat_q) + 1'b1));

    assert_release_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_valid_n && cmd_out[0]) |=> (ext_valid_n && !ad_oe && !cmd_oe));

    assert_reject_stays_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && (cmd_valid_n || cmd_in[CMD_DATA_BIT] || cmd_in[CMD_WRITE_BIT]))
        |=> (state_q == ST_IDLE && ext_valid_n));

    assert_read_feeds_beat_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !ext_valid_n);

    assert_bad_no_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == KIND_BAD && state_q != ST_IDLE) |-> !mem_rd_en);

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

// File: tb/test_mbus_read_responder.sv
`timescale 1ns/1ps
module test_mbus_read_responder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid_n = 1'b1;
    logic [4:0]  cmd_in = 5'h1F;
    logic [31:0] ad_in = '0;
    logic [3:0]  wait_cycles = '0;
    logic [31:0] ad_out;
    logic        ad_oe;
    logic [4:0]  cmd_out;
    logic        cmd_oe;
    logic        ext_valid_n;
    logic        mem_rd_en;
    logic [29:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        err_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int mem_reads = 0;

    always #5 clk = ~clk;

    mbus_read_responder i_mbus_read_responder (
        .clk(clk), .rst_n(rst_n), .cmd_valid_n(cmd_valid_n), .cmd_in(cmd_in),
        .ad_in(ad_in), .wait_cycles(wait_cycles), .ad_out(ad_out), .ad_oe(ad_oe),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .ext_valid_n(ext_valid_n),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .err_o(err_o)
    );

    // memory model: word = {2'b01, word address}, one cycle latency
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= {2'b01, mem_addr};
            mem_reads <= mem_reads + 1;
        end
    end

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: act=hung exp=done");
            report();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [1:0] sz, input logic [31:0] a, input int b);
        logic [1:0] o2;
        case (sz)
            2'b00: exp_word = {2'b01, a[31:2]};
            2'b01: begin
                o2 = b[1:0];
                if (a[4]) o2[1] = b[1] ^ a[3];
                exp_word = {2'b01, a[31:4], o2};
            end
            2'b10: exp_word = {2'b01, a[31:5], b[2:0]};
            default: exp_word = 32'h0;
        endcase
    endfunction

    // issue a read, check latency, every beat, release and memory traffic
    task automatic run_read(input logic [1:0] sz, input logic [31:0] a, input logic [3:0] w,
                            input string tag);
        int nb;
        int r0;
        nb = (sz == 2'b01) ? 4 : (sz == 2'b10) ? 8 : 1;
        @(negedge clk);
        r0 = mem_reads;
        cmd_valid_n = 1'b0;
        cmd_in      = {3'b000, sz};
        ad_in       = a;
        wait_cycles = w;
        @(posedge clk);
        @(negedge clk);
        cmd_valid_n = 1'b1;
        cmd_in      = 5'h1F;
        ad_in       = 32'hDEAD_BEEF;
        wait_cycles = 4'hA;
        // R4: quiet through the wait
        for (int i = 0; i <= int'(w); i++) begin
            if (i > 0) @(negedge clk);
            check("R4 wait quiet", {30'b0, ext_valid_n, ad_oe}, 32'h2);
        end
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            check({tag, " data"}, ad_out, exp_word(sz, a, b));
            check("R5 beat strobe", {27'b0, ext_valid_n, ad_oe, cmd_oe, cmd_out[4], cmd_out[0]},
                  {27'b0, 1'b0, 1'b1, 1'b1, 1'b1, (b == nb - 1)});
        end
        @(negedge clk);
        check("R10 release", {29'b0, ext_valid_n, ad_oe, cmd_oe}, 32'h4);
        check("R12 read count", mem_reads - r0, (sz == 2'b11) ? 0 : nb);
    endtask

    task automatic expect_quiet(input int n, input string req);
        int busy;
        int r0;
        busy = 0;
        r0 = mem_reads;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!ext_valid_n || ad_oe) busy++;
        end
        check(req, busy, 0);
        check(req, mem_reads - r0, 0);
    endtask

    // {size, address, wait}
    localparam logic [37:0] VEC [8] = '{
        {2'b00, 32'h0000_1234, 4'd0},   // R6
        {2'b00, 32'h8000_FFFC, 4'd3},   // R6
        {2'b01, 32'h0000_0100, 4'd1},   // R7
        {2'b01, 32'h0000_0218, 4'd0},   // R8 order 2,3,0,1
        {2'b01, 32'h0000_0310, 4'd2},   // R8 lower half first
        {2'b01, 32'h0000_0408, 4'd0},   // R7 bit 3 set, bit 4 clear
        {2'b10, 32'h0000_1000, 4'd0},   // R9
        {2'b10, 32'h0000_203C, 4'd15}   // R9 low bits ignored
    };

    initial begin
        // R1 reset state
        #2;
        check("R1 reset", {27'b0, ad_oe, cmd_oe, mem_rd_en, err_o, ext_valid_n}, 32'h1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_quiet(4, "R1 idle after reset");

        for (int v = 0; v < 8; v++) begin
            logic [1:0] sz;
            sz = VEC[v][37:36];
            run_read(sz, VEC[v][35:4], VEC[v][3:0],
                     (sz == 2'b00) ? "R6" : (sz == 2'b10) ? "R9" : (VEC[v][8] ? "R8" : "R7"));
        end
        check("R11 no error yet", {31'b0, err_o}, 32'h0);

        // R3: cmd_in[2] has no effect on the size
        @(negedge clk);
        cmd_valid_n = 1'b0; cmd_in = 5'b00101; ad_in = 32'h0000_0500; wait_cycles = 4'd0;
        @(posedge clk); @(negedge clk);
        cmd_valid_n = 1'b1; cmd_in = 5'h1F;
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            check("R3 bit2 ignored", ad_out, exp_word(2'b01, 32'h0000_0500, b));
        end
        @(negedge clk);
        check("R3 four beats", {31'b0, ext_valid_n}, 32'h1);

        // R2: write command ignored
        @(negedge clk);
        cmd_valid_n = 1'b0; cmd_in = 5'b01000; ad_in = 32'h40;
        @(negedge clk);
        cmd_valid_n = 1'b1; cmd_in = 5'h1F;
        expect_quiet(20, "R2 write ignored");
        // R2: data cycle ignored
        cmd_valid_n = 1'b0; cmd_in = 5'b10000;
        @(negedge clk);
        cmd_valid_n = 1'b1; cmd_in = 5'h1F;
        expect_quiet(20, "R2 data cycle ignored");
        // R2: read command without strobe ignored
        cmd_valid_n = 1'b1; cmd_in = 5'b00000;
        @(negedge clk);
        cmd_in = 5'h1F;
        expect_quiet(20, "R2 no strobe ignored");

        // R10: request held only in the turnaround cycle is dropped
        run_read(2'b00, 32'h0000_0044, 4'd0, "R6");
        cmd_valid_n = 1'b0; cmd_in = 5'b00000; ad_in = 32'h0000_0080; wait_cycles = 4'd0;
        @(negedge clk);
        cmd_valid_n = 1'b1; cmd_in = 5'h1F;
        expect_quiet(20, "R10 turnaround ignored");

        // R11: unsupported size
        run_read(2'b11, 32'h0000_0600, 4'd2, "R11");
        check("R11 error set", {31'b0, err_o}, 32'h1);
        run_read(2'b00, 32'h0000_0700, 4'd1, "R6");
        check("R11 error sticky", {31'b0, err_o}, 32'h1);

        report();
    end

endmodule